// File: doc/BRIEF.md
# SRAM Slave with Early Completion Count

This block is a bus slave in front of an asynchronous static RAM. A master issues a read or a write by raising a strobe for a single clock cycle, with the address and write data valid in that same cycle only. The slave latches everything it needs on that edge. It then runs the external access by itself, so the master is free to carry on straight away.

The slave has no late acknowledge. Instead it drives a small down-counter that gives the number of clock edges left before read data is valid or the write has retired. A master that knows the result will arrive in one or two cycles can restart its pipeline early. Read data is kept in a register and stays on the output until a later read completes.

The RAM strobes are active low and come straight from flip-flops, so they can be placed in pad registers. The RAM address and the write data also come straight from flip-flops.

Top module: `sram_early_slave`

## Requirements
- R1: After reset, `rdy_cnt` is 0, `sram_ncs`, `sram_noe` and `sram_nwe` are 1, `sram_dout_en` is 0 and `rd_data` is 0.
- R2: A command is accepted on a clock edge where `cmd_rd` or `cmd_wr` is 1 and `rdy_cnt` is 0. On that edge `cmd_addr` is copied to `sram_addr` and `cmd_wdata` is copied to `sram_dout`. Both hold these values until the next accepted command.
- R3: For an accepted read, `rdy_cnt` reads 2, 1 and then 0 in the three cycles after the accepting edge (`RD_CYCLES` = 3). When it reaches 0, `rd_data` equals the RAM word at the latched address, sampled on the edge where the count goes from 1 to 0.
- R4: During a read, `sram_ncs` and `sram_noe` are 0 exactly while `rdy_cnt` is nonzero, and `sram_nwe` stays 1. `sram_noe` and `sram_nwe` are never 0 together.
- R5: For an accepted write, `rdy_cnt` starts at `WR_CYCLES`-1. While the count is nonzero, `sram_ncs` is 0 and `sram_dout_en` is 1. `sram_nwe` is 0 only while the count is 2 or more, so it rises one cycle before the count reaches 0.
- R6: `rd_data` changes only on the edge where a read completes. Idle cycles, writes and pending reads leave it unchanged.
- R7: A command presented while `rdy_cnt` is nonzero is ignored. The count, `sram_addr`, `sram_dout` and the result of the access in progress are not affected.
- R8: If `cmd_rd` and `cmd_wr` are both 1 on an accepting edge, the command is treated as a read and nothing is written.
- R9: While `rdy_cnt` is nonzero it falls by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rd | input | 1 | Read strobe, valid for one cycle |
| cmd_wr | input | 1 | Write strobe, valid for one cycle |
| cmd_addr | input | ADDR_W | Word address, valid with the strobe |
| cmd_wdata | input | DATA_W | Write data, valid with the strobe |
| rd_data | output | DATA_W | Held result of the last completed read |
| rdy_cnt | output | CNT_W | Cycles left until the access is complete (0 = idle) |
| sram_addr | output | ADDR_W | Registered RAM address |
| sram_dout | output | DATA_W | Registered RAM write data |
| sram_dout_en | output | 1 | Drive enable for the RAM data pins |
| sram_din | input | DATA_W | Data from the RAM pins |
| sram_ncs | output | 1 | RAM chip select, active low |
| sram_noe | output | 1 | RAM output enable, active low |
| sram_nwe | output | 1 | RAM write enable, active low |

## Verification
Directed cases cover the reset state, back-to-back reads and writes to the same word, and a command with both strobes set. Together they show that writes land in the RAM, that a read returns the newest word, and that a read takes priority over a write. Random sequences mix reads, writes and double-strobe commands over random addresses. During busy cycles they also inject random commands. Because the memory contents and the hold of `rd_data` are compared after each access, any capture of a busy-time command is exposed, as is a lost address hold. The count and strobe levels are checked in every busy cycle, which separates a correct early rise of the write strobe from one that comes too early or too late.

// File: rtl/sram_es_pkg.sv
package sram_es_pkg;
   typedef enum logic {
      OP_WR = 1'b0,
      OP_RD = 1'b1
   } op_e;
endpackage

// File: rtl/sram_es_latch.sv
// Address and write-data holding registers, loaded on command acceptance.
module sram_es_latch #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         data_o <= '0;
      end else if (load) begin
         addr_o <= addr_i;
         data_o <= data_i;
      end
   end
endmodule

// File: rtl/sram_es_seq.sv
// Access sequencer: remaining-cycle counter and registered RAM strobes.
module sram_es_seq
   import sram_es_pkg::*;
#(
   parameter int CNT_W     = 2,
   parameter int RD_CYCLES = 3,
   parameter int WR_CYCLES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_rd,
   input  logic             req_wr,
   output logic             accept,
   output logic             capture,
   output logic [CNT_W-1:0] cnt,
   output logic             ncs,
   output logic             noe,
   output logic             nwe,
   output logic             den
);
   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYCLES - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYCLES - 1);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

   generate
      if (RD_CYCLES < 2 || RD_CYCLES - 1 >= (1 << CNT_W)) begin : g_bad_rd
         $error("RD_CYCLES must be at least 2 and fit the counter");
      end
      if (WR_CYCLES < 3 || WR_CYCLES - 1 >= (1 << CNT_W)) begin : g_bad_wr
         $error("WR_CYCLES must be at least 3 and fit the counter");
      end
   endgenerate

   op_e op_q;
   logic is_rd;

   assign is_rd   = req_rd;                       // read wins over write
   assign accept  = (req_rd | req_wr) && (cnt == '0);
   assign capture = (op_q == OP_RD) && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         op_q <= OP_WR;
         ncs  <= 1'b1;
         noe  <= 1'b1;
         nwe  <= 1'b1;
         den  <= 1'b0;
      end else if (accept) begin
         op_q <= is_rd ? OP_RD : OP_WR;
         cnt  <= is_rd ? RD_LOAD : WR_LOAD;
         ncs  <= 1'b0;
         noe  <= !is_rd;
         nwe  <= is_rd;
         den  <= !is_rd;
      end else if (cnt != '0) begin
         cnt <= cnt - ONE;
         if (cnt == TWO) nwe <= 1'b1;
         if (cnt == ONE) begin
            ncs <= 1'b1;
            noe <= 1'b1;
            nwe <= 1'b1;
            den <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sram_es_hold.sv
// Read-result register: loads only when a read completes, holds otherwise.
module sram_es_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout <= '0;
      else if (capture) dout <= din;
   end
endmodule

// File: rtl/sram_early_slave.sv
module sram_early_slave #(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 2,
   parameter int RD_CYCLES = 3,
   parameter int WR_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_rd,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  rdy_cnt,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dout,
   output logic              sram_dout_en,
   input  logic [DATA_W-1:0] sram_din,
   output logic              sram_ncs,
   output logic              sram_noe,
   output logic              sram_nwe
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic accept;
   logic capture;

   sram_es_seq #(
      .CNT_W(CNT_W), .RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .req_rd(cmd_rd), .req_wr(cmd_wr),
      .accept(accept), .capture(capture), .cnt(rdy_cnt),
      .ncs(sram_ncs), .noe(sram_noe), .nwe(sram_nwe), .den(sram_dout_en)
   );

   sram_es_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_latch (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .addr_i(cmd_addr), .data_i(cmd_wdata),
      .addr_o(sram_addr), .data_o(sram_dout)
   );

   sram_es_hold #(.DATA_W(DATA_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .din(sram_din), .dout(rd_data)
   );

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt != '0) |=> ($stable(sram_addr) && $stable(sram_dout))); // R2

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt != '0) |=> (rdy_cnt == CNT_W'($past(rdy_cnt) - 1'b1))); // R9

   AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ((rdy_cnt != '0) == !sram_ncs)); // R4

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_noe && !sram_nwe)); // R4

   AST_NWE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_nwe) |-> (rdy_cnt == CNT_W'(1))); // R5

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_cnt != CNT_W'(1)) |=> $stable(rd_data)); // R6
endmodule

// File: tb/test_sram_early_slave.sv
`timescale 1ns/1ps
module test_sram_early_slave;
   localparam int AW = 18;
   localparam int DW = 32;
   localparam int CW = 2;
   localparam int RDC = 3;
   localparam int WRC = 3;
   localparam int MD = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_rd = 1'b0, cmd_wr = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic [DW-1:0] rd_data, sram_dout, sram_din;
   logic [CW-1:0] rdy_cnt;
   logic [AW-1:0] sram_addr;
   logic sram_dout_en, sram_ncs, sram_noe, sram_nwe;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] mem [MD];
   logic [DW-1:0] shadow [MD];
   logic [DW-1:0] last_rd = '0;

   always #10 clk = ~clk;

   sram_early_slave #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
      .RD_CYCLES(RDC), .WR_CYCLES(WRC)) i_sram_early_slave (
      .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
      .rdy_cnt(rdy_cnt), .sram_addr(sram_addr), .sram_dout(sram_dout),
      .sram_dout_en(sram_dout_en), .sram_din(sram_din), .sram_ncs(sram_ncs),
      .sram_noe(sram_noe), .sram_nwe(sram_nwe));

   // simple asynchronous RAM model
   assign sram_din = (!sram_ncs && !sram_noe) ? mem[sram_addr[7:0]] : '0;
   always @(posedge sram_nwe)
      if (rst_n && !sram_ncs) mem[sram_addr[7:0]] <= sram_dout;

   function automatic logic [DW-1:0] seed_word(int i);
      return DW'(i) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one command, checked cycle by cycle; optional junk during busy cycles
   task automatic run_cmd(logic rd, logic wr, logic [AW-1:0] a,
                          logic [DW-1:0] d, logic junk);
      logic is_rd;
      int n;
      logic [DW-1:0] exp;
      is_rd = rd;
      n = is_rd ? RDC - 1 : WRC - 1;
      exp = shadow[a[7:0]];
      @(negedge clk);
      cmd_rd = rd; cmd_wr = wr; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      chk("R3/R5 start count", 64'(rdy_cnt), 64'(n));
      for (int k = n; k >= 1; k--) begin
         chk("R9 count step", 64'(rdy_cnt), 64'(k));
         chk("R2 addr hold", 64'(sram_addr), 64'(a));
         chk("R4/R5 ncs", 64'(sram_ncs), 64'd0);
         chk("R6 rd_data hold while busy", 64'(rd_data), 64'(last_rd));
         if (is_rd) begin
            chk("R4 noe", 64'(sram_noe), 64'd0);
            chk("R4/R8 nwe", 64'(sram_nwe), 64'd1);
         end else begin
            chk("R2 wdata hold", 64'(sram_dout), 64'(d));
            chk("R5 dout_en", 64'(sram_dout_en), 64'd1);
            chk("R5 nwe early", 64'(sram_nwe), (k >= 2) ? 64'd0 : 64'd1);
         end
         if (junk) begin   // R7 stimulus
            cmd_rd = 1'($urandom); cmd_wr = 1'($urandom);
            cmd_addr = AW'($urandom); cmd_wdata = $urandom;
         end else begin
            cmd_rd = 1'b0; cmd_wr = 1'b0;
         end
         @(negedge clk);
      end
      cmd_rd = 1'b0; cmd_wr = 1'b0;
      chk("R3 count done", 64'(rdy_cnt), 64'd0);
      chk("R4 ncs idle", 64'(sram_ncs), 64'd1);
      chk("R7 addr not overwritten", 64'(sram_addr), 64'(a));
      if (is_rd) begin
         chk("R3 read data", 64'(rd_data), 64'(exp));
         last_rd = exp;
      end else begin
         chk("R6 rd_data kept over write", 64'(rd_data), 64'(last_rd));
         shadow[a[7:0]] = d;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < MD; i++) begin
         mem[i] = seed_word(i);
         shadow[i] = seed_word(i);
      end
      repeat (3) @(negedge clk);
      chk("R1 cnt", 64'(rdy_cnt), 64'd0);
      chk("R1 ncs", 64'(sram_ncs), 64'd1);
      chk("R1 noe", 64'(sram_noe), 64'd1);
      chk("R1 nwe", 64'(sram_nwe), 64'd1);
      chk("R1 dout_en", 64'(sram_dout_en), 64'd0);
      chk("R1 rd_data", 64'(rd_data), 64'd0);
      rst_n = 1'b1;
      // directed cases
      run_cmd(1'b1, 1'b0, AW'(5), '0, 1'b0);
      run_cmd(1'b0, 1'b1, AW'(5), 32'hCAFE_0001, 1'b0);
      run_cmd(1'b1, 1'b0, AW'(5), '0, 1'b0);
      run_cmd(1'b1, 1'b1, AW'(9), 32'hDEAD_BEEF, 1'b0);   // R8: read wins
      run_cmd(1'b1, 1'b0, AW'(9), '0, 1'b0);               // R8: not written
      run_cmd(1'b0, 1'b1, AW'(255), 32'hFFFF_FFFF, 1'b1);  // R7 junk
      run_cmd(1'b1, 1'b0, AW'(255), '0, 1'b1);
      // idle cycles leave rd_data alone (R6)
      repeat (4) @(negedge clk);
      chk("R6 idle hold", 64'(rd_data), 64'(last_rd));
      // constrained random mix
      for (int it = 0; it < 300; it++) begin
         int op;
         op = $urandom % 3;
         run_cmd(op != 1, op != 0, AW'($urandom), $urandom, 1'($urandom));
      end
      for (int i = 0; i < 16; i++)
         run_cmd(1'b1, 1'b0, AW'(i * 16 + 3), '0, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule